// File: doc/BRIEF.md
# Single-Precision Compare and Conditional-Move Unit

This execution unit takes one instruction of a floating-point group per cycle. There are two kinds. The first kind compares two binary32 operands and writes a single predicate bit into a 16-bit boolean register that the unit holds. The second kind copies one float value into a float register when a condition holds. The condition comes either from an integer operand or from a bit of the boolean register. The register file lives outside the unit. Operands arrive already read from it, and a taken move leaves the unit as a write-enable, a write address and write data.

Instructions enter on an `in_valid` strobe, and `in_ready` is always high, so the unit never applies back-pressure. The boolean register and a sticky invalid-operation flag are updated on the clock edge that captures a valid instruction. The float write port is combinational: it is valid in the same cycle as the strobe, and the register file is expected to capture it at that edge. Opcodes that are not defined assert `rsvd_op` and change nothing.

Top module: `fpcu_top`

## Requirements
- R1: The opcode selects the compare predicate of s against t. The encodings are: 1 unordered, 2 ordered-equal, 3 unordered-or-equal, 4 ordered-less, 5 unordered-or-less, 6 ordered-less-or-equal, 7 unordered-or-less-or-equal.
- R2: A compare writes its result into bit `r_idx` of `bool_q` only. The other 15 bits keep their values.
- R3: The unordered-or predicates (3, 5, 7) are true when either operand is a NaN. Predicate 7 is true exactly when the relation is not "greater".
- R4: The ordered predicates (2, 4, 6) are false whenever either operand is a NaN. A NaN has an exponent of all ones and a nonzero mantissa.
- R5: +0 and -0 compare equal. Otherwise, ordering follows sign and magnitude, with magnitude order reversed for negative values.
- R6: Opcodes 8, 9, 10 and 11 assert `fr_we` when `at_val` is, in that order: zero, nonzero, negative as a signed value, and non-negative. In that case `fr_waddr`=`r_idx` and `fr_wdata`=`fs_val`. Otherwise `fr_we` stays low.
- R7: Opcode 12 asserts `fr_we` when `bool_q[t_idx]` is 0. Opcode 13 asserts it when that bit is 1.
- R8: Opcodes 0, 14 and 15 raise `rsvd_op` while valid. They leave `bool_q` and `inv_flag` unchanged and keep `fr_we` low.
- R9: A compare with a signaling NaN operand (mantissa bit 22 clear) sets `inv_flag`. A quiet NaN does not set it. The flag stays set until reset, and moves never set it.
- R10: Reset clears `bool_q` and `inv_flag`. With `in_valid` low, no state changes and `fr_we` stays low.
- R11: `fr_we` is high only for a taken move. `in_ready` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction strobe |
| in_ready | output | 1 | Always high; the unit takes one instruction per cycle |
| op | input | 4 | Opcode subfield |
| r_idx | input | 4 | Destination: boolean bit for compares, float register for moves |
| t_idx | input | 4 | Boolean bit that gates opcodes 12 and 13 |
| fs_val | input | 32 | Float operand s |
| ft_val | input | 32 | Float operand t |
| at_val | input | 32 | Integer operand t |
| bool_q | output | 16 | Boolean register |
| fr_we | output | 1 | Float register write-enable |
| fr_waddr | output | 4 | Float register write address |
| fr_wdata | output | 32 | Float register write data |
| rsvd_op | output | 1 | Reserved-opcode indication |
| inv_flag | output | 1 | Sticky invalid-operation flag |

## Verification
The hardest cases to reach involve state left by earlier instructions. The boolean-gated moves read bits that only compares can set. The invalid flag is sticky, so once it is set, a later test can no longer tell whether a quiet NaN would have set it. The stimulus first runs all quiet-NaN compares from a vector table and checks that the flag is still clear. Only then does it issue a signaling-NaN compare. It also writes known values into chosen boolean bits with compares before it tries moves gated on those bits.

// File: rtl/fpcu_pkg.sv
package fpcu_pkg;
  parameter int FLEN  = 32;
  parameter int EXP_W = 8;
  parameter int MAN_W = 23;
  parameter int IDX_W = 4;
  localparam int BR_N = 1 << IDX_W;

  typedef enum logic [3:0] {
    OP_RSV0  = 4'd0,
    OP_UN    = 4'd1,
    OP_OEQ   = 4'd2,
    OP_UEQ   = 4'd3,
    OP_OLT   = 4'd4,
    OP_ULT   = 4'd5,
    OP_OLE   = 4'd6,
    OP_ULE   = 4'd7,
    OP_MEQZ  = 4'd8,
    OP_MNEZ  = 4'd9,
    OP_MLTZ  = 4'd10,
    OP_MGEZ  = 4'd11,
    OP_MBF   = 4'd12,
    OP_MBT   = 4'd13,
    OP_RSV14 = 4'd14,
    OP_RSV15 = 4'd15
  } fop_e;

  function automatic logic is_cmp(input fop_e o);
    return (o >= OP_UN) && (o <= OP_ULE);
  endfunction

  function automatic logic is_mov(input fop_e o);
    return (o >= OP_MEQZ) && (o <= OP_MBT);
  endfunction
endpackage

// File: rtl/fp_classify.sv
module fp_classify #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0]   val,
  output logic                   sign,
  output logic [EXP_W+MAN_W-1:0] mag,
  output logic                   is_nan,
  output logic                   is_snan,
  output logic                   is_zero
);
  logic [EXP_W-1:0] expo;
  logic [MAN_W-1:0] mant;

  always_comb begin
    sign    = val[EXP_W+MAN_W];
    mag     = val[EXP_W+MAN_W-1:0];
    expo    = val[EXP_W+MAN_W-1:MAN_W];
    mant    = val[MAN_W-1:0];
    is_nan  = (&expo) && (|mant);
    is_snan = is_nan && !mant[MAN_W-1];
    is_zero = (mag == '0);
  end
endmodule

// File: rtl/fp_relate.sv
module fp_relate #(
  parameter int MAG_W = 31
) (
  input  logic             a_sign,
  input  logic [MAG_W-1:0] a_mag,
  input  logic             a_nan,
  input  logic             a_zero,
  input  logic             b_sign,
  input  logic [MAG_W-1:0] b_mag,
  input  logic             b_nan,
  input  logic             b_zero,
  output logic             unord,
  output logic             eq,
  output logic             lt,
  output logic             gt
);
  logic same_bits, mag_lt;

  always_comb begin
    unord     = a_nan || b_nan;
    same_bits = (a_sign == b_sign) && (a_mag == b_mag);
    eq        = !unord && (same_bits || (a_zero && b_zero));
    mag_lt    = a_mag < b_mag;
    if (unord || eq)
      lt = 1'b0;
    else if (a_sign != b_sign)
      lt = a_sign;
    else if (a_sign)
      lt = !mag_lt;
    else
      lt = mag_lt;
    gt = !unord && !eq && !lt;
  end
endmodule

// File: rtl/fp_move_gate.sv
module fp_move_gate
  import fpcu_pkg::*;
#(
  parameter int IW = 32
) (
  input  fop_e          opc,
  input  logic [IW-1:0] ival,
  input  logic          bbit,
  output logic          take
);
  always_comb begin
    unique case (opc)
      OP_MEQZ: take = (ival == '0);
      OP_MNEZ: take = (ival != '0);
      OP_MLTZ: take = ival[IW-1];
      OP_MGEZ: take = !ival[IW-1];
      OP_MBF:  take = !bbit;
      OP_MBT:  take = bbit;
      default: take = 1'b0;
    endcase
  end
endmodule

// File: rtl/fpcu_top.sv
module fpcu_top
  import fpcu_pkg::*;
#(
  parameter int W  = fpcu_pkg::FLEN,
  parameter int EW = fpcu_pkg::EXP_W,
  parameter int MW = fpcu_pkg::MAN_W,
  parameter int IW = fpcu_pkg::IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [3:0]        op,
  input  logic [IW-1:0]     r_idx,
  input  logic [IW-1:0]     t_idx,
  input  logic [W-1:0]      fs_val,
  input  logic [W-1:0]      ft_val,
  input  logic [W-1:0]      at_val,
  output logic [(1<<IW)-1:0] bool_q,
  output logic              fr_we,
  output logic [IW-1:0]     fr_waddr,
  output logic [W-1:0]      fr_wdata,
  output logic              rsvd_op,
  output logic              inv_flag
);
  localparam int NB  = 1 << IW;
  localparam int MAG = EW + MW;

  fop_e opc;
  assign opc = fop_e'(op);

  logic [W-1:0]   opnd  [2];
  logic           sgn   [2];
  logic [MAG-1:0] mag   [2];
  logic           nan   [2];
  logic           snan  [2];
  logic           zro   [2];

  assign opnd[0] = fs_val;
  assign opnd[1] = ft_val;

  for (genvar g = 0; g < 2; g++) begin : g_cls
    fp_classify #(.EXP_W(EW), .MAN_W(MW)) u_cls (
      .val(opnd[g]), .sign(sgn[g]), .mag(mag[g]),
      .is_nan(nan[g]), .is_snan(snan[g]), .is_zero(zro[g])
    );
  end

  logic unord, eq, lt, gt;
  fp_relate #(.MAG_W(MAG)) u_rel (
    .a_sign(sgn[0]), .a_mag(mag[0]), .a_nan(nan[0]), .a_zero(zro[0]),
    .b_sign(sgn[1]), .b_mag(mag[1]), .b_nan(nan[1]), .b_zero(zro[1]),
    .unord(unord), .eq(eq), .lt(lt), .gt(gt)
  );

  logic pred;
  always_comb begin
    unique case (opc)
      OP_UN:   pred = unord;
      OP_OEQ:  pred = eq;
      OP_UEQ:  pred = eq || unord;
      OP_OLT:  pred = lt;
      OP_ULT:  pred = lt || unord;
      OP_OLE:  pred = lt || eq;
      OP_ULE:  pred = !gt;
      default: pred = 1'b0;
    endcase
  end

  logic take;
  fp_move_gate #(.IW(W)) u_gate (
    .opc(opc), .ival(at_val), .bbit(bool_q[t_idx]), .take(take)
  );

  logic do_cmp;
  assign do_cmp = in_valid && is_cmp(opc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bool_q   <= '0;
      inv_flag <= 1'b0;
    end else if (do_cmp) begin
      bool_q[r_idx] <= pred;
      if (snan[0] || snan[1]) inv_flag <= 1'b1;
    end
  end

  assign in_ready = 1'b1;
  assign fr_we    = in_valid && is_mov(opc) && take;
  assign fr_waddr = r_idx;
  assign fr_wdata = fs_val;
  assign rsvd_op  = in_valid && !is_cmp(opc) && !is_mov(opc);

  assert_other_bits_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (((bool_q ^ $past(bool_q)) & ~(NB'(1) << $past(r_idx))) == '0));

  assert_rsvd_no_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsvd_op |=> ($stable(bool_q) && $stable(inv_flag)));

  assert_we_only_move_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fr_we |-> (in_valid && op >= 4'd8 && op <= 4'd13));

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    inv_flag |=> inv_flag);

  assert_idle_no_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(bool_q) && $stable(inv_flag)));

  assert_relation_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> $onehot({unord, eq, lt, gt}));
endmodule

// File: tb/tb_fpcu_top.sv
module tb_fpcu_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] ONE  = 32'h3F80_0000, TWO  = 32'h4000_0000;
  localparam logic [31:0] MONE = 32'hBF80_0000, MTWO = 32'hC000_0000;
  localparam logic [31:0] PZ   = 32'h0000_0000, NZ   = 32'h8000_0000;
  localparam logic [31:0] QNAN = 32'h7FC0_0000, SNAN = 32'h7F80_0001;
  localparam logic [31:0] INF  = 32'h7F80_0000;
  localparam int NV = 20;
  localparam logic [68:0] VEC [NV] = '{
    {4'd1, ONE,  QNAN, 1'b1}, {4'd1, ONE,  TWO,  1'b0},
    {4'd2, ONE,  ONE,  1'b1}, {4'd2, PZ,   NZ,   1'b1},
    {4'd2, QNAN, QNAN, 1'b0}, {4'd3, QNAN, ONE,  1'b1},
    {4'd3, ONE,  TWO,  1'b0}, {4'd4, ONE,  TWO,  1'b1},
    {4'd4, MTWO, MONE, 1'b1}, {4'd4, MONE, MTWO, 1'b0},
    {4'd4, ONE,  QNAN, 1'b0}, {4'd5, QNAN, ONE,  1'b1},
    {4'd5, TWO,  ONE,  1'b0}, {4'd6, ONE,  ONE,  1'b1},
    {4'd6, TWO,  ONE,  1'b0}, {4'd6, MONE, ONE,  1'b1},
    {4'd7, TWO,  ONE,  1'b0}, {4'd7, QNAN, TWO,  1'b1},
    {4'd7, ONE,  INF,  1'b1}, {4'd4, NZ,   PZ,   1'b0}
  };

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [3:0] op = 0, r_idx = 0, t_idx = 0;
  logic [31:0] fs_val = 0, ft_val = 0, at_val = 0;
  logic in_ready, fr_we, rsvd_op, inv_flag;
  logic [15:0] bool_q;
  logic [3:0] fr_waddr;
  logic [31:0] fr_wdata;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [15:0] model = '0;
  logic s_we, s_rsvd;
  logic [3:0] s_wa;
  logic [31:0] s_wd;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpcu_top dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op(op), .r_idx(r_idx), .t_idx(t_idx), .fs_val(fs_val), .ft_val(ft_val),
    .at_val(at_val), .bool_q(bool_q), .fr_we(fr_we), .fr_waddr(fr_waddr),
    .fr_wdata(fr_wdata), .rsvd_op(rsvd_op), .inv_flag(inv_flag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] o, input logic [3:0] r, input logic [3:0] t,
                       input logic [31:0] a, input logic [31:0] b, input logic [31:0] iv,
                       input logic v);
    @(negedge clk);
    op = o; r_idx = r; t_idx = t; fs_val = a; ft_val = b; at_val = iv; in_valid = v;
    #1;
    s_we = fr_we; s_rsvd = rsvd_op; s_wa = fr_waddr; s_wd = fr_wdata;
    @(negedge clk);
    in_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 reset bool", {16'h0, bool_q}, 32'h0);
    chk("R10 reset flag", {31'h0, inv_flag}, 32'h0);
    chk("R11 ready", {31'h0, in_ready}, 32'h1);

    // R1 R2 R3 R4 R5: table walk, one bit per vector, whole register tracked
    for (int i = 0; i < NV; i++) begin
      logic [3:0] r;
      r = 4'(i % 16);
      issue(VEC[i][68:65], r, 4'd0, VEC[i][64:33], VEC[i][32:1], 32'h0, 1'b1);
      model[r] = VEC[i][0];
      chk($sformatf("R1 R2 vector %0d", i), {16'h0, bool_q}, {16'h0, model});
      chk($sformatf("R11 no write on compare %0d", i), {31'h0, s_we}, 32'h0);
    end
    chk("R9 quiet NaN leaves flag clear", {31'h0, inv_flag}, 32'h0);

    // R10: idle compare does nothing
    issue(4'd2, 4'd9, 4'd0, ONE, ONE, 32'h0, 1'b0);
    chk("R10 idle keeps bool", {16'h0, bool_q}, {16'h0, model});

    // R9: signaling NaN
    issue(4'd2, 4'd0, 4'd0, SNAN, ONE, 32'h0, 1'b1);
    model[0] = 1'b0;
    chk("R9 snan sets flag", {31'h0, inv_flag}, 32'h1);
    chk("R4 snan ordered-equal false", {16'h0, bool_q}, {16'h0, model});

    // R6: integer-gated moves
    issue(4'd8, 4'd7, 4'd0, TWO, ONE, 32'h0, 1'b1);
    chk("R6 eqz taken", {31'h0, s_we}, 32'h1);
    chk("R6 waddr", {28'h0, s_wa}, 32'h7);
    chk("R6 wdata", s_wd, TWO);
    issue(4'd8, 4'd7, 4'd0, TWO, ONE, 32'h5, 1'b1);
    chk("R6 eqz not taken", {31'h0, s_we}, 32'h0);
    issue(4'd9, 4'd3, 4'd0, MONE, ONE, 32'h5, 1'b1);
    chk("R6 nez taken", {31'h0, s_we}, 32'h1);
    issue(4'd10, 4'd3, 4'd0, MONE, ONE, 32'h8000_0000, 1'b1);
    chk("R6 ltz taken", {31'h0, s_we}, 32'h1);
    issue(4'd10, 4'd3, 4'd0, MONE, ONE, 32'h1, 1'b1);
    chk("R6 ltz not taken", {31'h0, s_we}, 32'h0);
    issue(4'd11, 4'd3, 4'd0, MONE, ONE, 32'h0, 1'b1);
    chk("R6 gez taken on zero", {31'h0, s_we}, 32'h1);
    issue(4'd11, 4'd3, 4'd0, MONE, ONE, 32'hFFFF_FFFF, 1'b1);
    chk("R6 gez not taken", {31'h0, s_we}, 32'h0);
    chk("R9 moves keep flag", {31'h0, inv_flag}, 32'h1);

    // R7: boolean-gated moves; preload bit 5 = 1, bit 6 = 0
    issue(4'd2, 4'd5, 4'd0, ONE, ONE, 32'h0, 1'b1);
    issue(4'd2, 4'd6, 4'd0, ONE, TWO, 32'h0, 1'b1);
    model[5] = 1'b1; model[6] = 1'b0;
    chk("R7 preload", {16'h0, bool_q}, {16'h0, model});
    issue(4'd12, 4'd1, 4'd6, ONE, TWO, 32'h0, 1'b1);
    chk("R7 movf on clear bit", {31'h0, s_we}, 32'h1);
    issue(4'd12, 4'd1, 4'd5, ONE, TWO, 32'h0, 1'b1);
    chk("R7 movf on set bit", {31'h0, s_we}, 32'h0);
    issue(4'd13, 4'd1, 4'd5, ONE, TWO, 32'h0, 1'b1);
    chk("R7 movt on set bit", {31'h0, s_we}, 32'h1);
    issue(4'd13, 4'd1, 4'd6, ONE, TWO, 32'h0, 1'b1);
    chk("R7 movt on clear bit", {31'h0, s_we}, 32'h0);

    // R8: reserved opcodes
    foreach (model[k]) if (k < 0) model[k] = 1'b0;
    for (int j = 0; j < 3; j++) begin
      logic [3:0] o;
      o = (j == 0) ? 4'd0 : (j == 1) ? 4'd14 : 4'd15;
      issue(o, 4'd5, 4'd5, SNAN, ONE, 32'h0, 1'b1);
      chk($sformatf("R8 rsvd raised op %0d", o), {31'h0, s_rsvd}, 32'h1);
      chk($sformatf("R8 no write op %0d", o), {31'h0, s_we}, 32'h0);
      chk($sformatf("R8 bool kept op %0d", o), {16'h0, bool_q}, {16'h0, model});
    end
    chk("R8 flag kept", {31'h0, inv_flag}, 32'h1);

    // R10: reset again
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk("R10 reset clears bool", {16'h0, bool_q}, 32'h0);
    chk("R10 reset clears flag", {31'h0, inv_flag}, 32'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule